// File: doc/BRIEF.md
# DMA Bus-Slot Transfer Scheduler

This block paces data movement across three 16-bit internal buses: one for local memory, one for peripherals and one for external memory. A request names a source bus, a destination bus, an element width (8, 16 or 32 bits) and an element count. The scheduler then issues read and write beat strobes in the cycles that the bus resources allow, and raises a one-cycle done pulse after the final write beat. No data is carried; the strobes, bus codes, half-word index and byte enables tell the surrounding datapath what to move and when.

Throughput follows bus sharing. When source and destination are different non-peripheral buses, one beat moves per cycle. When source and destination are the same bus, the read and the write of each beat take separate cycles. When a peripheral is involved, beats are spaced at least one idle cycle apart. A 32-bit element is split into two 16-bit beats, low half first. An 8-bit element takes one beat with only the low byte enabled.

The block also holds a peripheral map for its 12 channels. Each channel has a 4-bit map field naming the peripheral request line that drives it. Reset loads the identity map. Software can rewrite any field. A value that names no peripheral disconnects the channel. When two channels name the same peripheral, the lower-numbered channel receives the request.

Top module: `dss_top`

## Requirements
- R1: After reset, ready_o is 1, no beat strobe or done pulse is active, and channel c is driven by peripheral request c.
- R2: Bus codes are 0 for local memory, 1 for peripheral and 2 for external memory (code 3 is taken as external). Width codes are 0 for 8-bit, 1 for 16-bit and 2 for 32-bit (code 3 is taken as 16-bit). A request is accepted on a clock edge where req_valid_i and ready_o are both 1. ready_o is 1 only while the block is idle.
- R3: When source and destination are different buses and neither is the peripheral bus, each beat asserts rd_beat_o and wr_beat_o in the same cycle, and beats follow on consecutive cycles. The first beat comes in the cycle after acceptance.
- R4: When source and destination are the same bus, each beat takes two cycles: rd_beat_o alone, then wr_beat_o alone.
- R5: When either side is the peripheral bus, no two write beats fall in consecutive cycles. For different buses, each beat asserts read and write together and is followed by one idle cycle, except after the last beat.
- R6: A 32-bit element takes two beats with beat_half_o 0 and then 1. During every beat of a 16-bit or 32-bit transfer, byte_en_o is 2'b11.
- R7: An 8-bit element takes one beat with byte_en_o equal to 2'b01. Outside beats, byte_en_o, beat_half_o and both bus outputs are 0.
- R8: done_o is high for exactly one cycle, in the cycle after the last write beat. The total number of write beats equals the count times the beats per element.
- R9: A request with count 0 produces no beats, and done_o rises in the cycle after acceptance.
- R10: A write with map_we_i sets the map field of channel map_chan_i to map_val_i from the next cycle on. A write that names a channel index of 12 or above changes no channel.
- R11: A channel whose map value is 12 or above drives chan_req_o low whatever the peripheral requests.
- R12: When several channels hold the same map value, only the lowest-numbered of them follows that peripheral request.
- R13: A request presented while the block is busy is ignored, and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Transfer request strobe |
| req_src_i | input | 2 | Source bus code |
| req_dst_i | input | 2 | Destination bus code |
| req_width_i | input | 2 | Element width code |
| req_count_i | input | CNT_W | Element count |
| ready_o | output | 1 | Idle, request can be accepted |
| rd_beat_o | output | 1 | Read beat strobe |
| rd_bus_o | output | 2 | Bus of current read beat |
| wr_beat_o | output | 1 | Write beat strobe |
| wr_bus_o | output | 2 | Bus of current write beat |
| beat_half_o | output | 1 | Half-word index within a 32-bit element |
| byte_en_o | output | 2 | Byte enables of the current beat |
| done_o | output | 1 | One-cycle completion pulse |
| map_we_i | input | 1 | Map field write enable |
| map_chan_i | input | CH_W | Channel index to write |
| map_val_i | input | MAP_W | New map value |
| periph_req_i | input | NUM_PERIPH | Peripheral request lines |
| chan_req_o | output | NUM_CHAN | Per-channel request after mapping |

## Verification
The bench builds the block with a 4-bit count (CNT_W = 4) and the default 12 channels, 12 peripherals and 4-bit map fields. With a 4-bit count, the largest count of 15 can be reached in a short run, so the full range of the element counter is exercised next to the zero-count case. With 4-bit map fields, values 12 to 15 are available to test the unconnected case. Channel index 13 is also available to check that an out-of-range map write changes nothing.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {BUS_LOCAL = 2'd0, BUS_PERIPH = 2'd1, BUS_EXT = 2'd2, BUS_RSVD = 2'd3} bus_e;
  typedef enum logic [1:0] {EW_8 = 2'd0, EW_16 = 2'd1, EW_32 = 2'd2, EW_RSVD = 2'd3} ew_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_DONE = 2'd2} st_e;
endpackage

// File: rtl/dss_beat_ctl.sv
module dss_beat_ctl
  import dss_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_src_i,
  input  logic [1:0]       req_dst_i,
  input  logic [1:0]       req_width_i,
  input  logic [CNT_W-1:0] req_count_i,
  output logic             ready_o,
  output logic             rd_beat_o,
  output logic [1:0]       rd_bus_o,
  output logic             wr_beat_o,
  output logic [1:0]       wr_bus_o,
  output logic             beat_half_o,
  output logic [1:0]       byte_en_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  st_e              st_q;
  bus_e             src_q, dst_q;
  ew_e              ew_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ph_q, half_q;

  logic accept, run, same, periph, two_cyc, wide, rd, wr, elem_done, last;

  function automatic bus_e norm_bus(input logic [1:0] b);
    return (b == 2'd3) ? BUS_EXT : bus_e'(b);
  endfunction

  assign accept    = (st_q == ST_IDLE) && req_valid_i;
  assign run       = (st_q == ST_RUN);
  assign same      = (src_q == dst_q);
  assign periph    = (src_q == BUS_PERIPH) || (dst_q == BUS_PERIPH);
  assign two_cyc   = same || periph;
  assign wide      = (ew_q == EW_32);
  assign rd        = run && !ph_q;
  assign wr        = run && (same ? ph_q : !ph_q);
  assign elem_done = wr && (!wide || half_q);
  assign last      = elem_done && (cnt_q == CNT_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      src_q  <= BUS_LOCAL;
      dst_q  <= BUS_LOCAL;
      ew_q   <= EW_16;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      half_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          src_q  <= norm_bus(req_src_i);
          dst_q  <= norm_bus(req_dst_i);
          ew_q   <= (req_width_i == 2'd3) ? EW_16 : ew_e'(req_width_i);
          cnt_q  <= req_count_i;
          ph_q   <= 1'b0;
          half_q <= 1'b0;
          st_q   <= (req_count_i == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          if (two_cyc) ph_q <= ~ph_q;
          if (wr) begin
            half_q <= wide && !half_q;
            if (elem_done) cnt_q <= cnt_q - CNT_ONE;
            if (last) begin
              st_q <= ST_DONE;
              ph_q <= 1'b0;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = (st_q == ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign rd_beat_o   = rd;
  assign wr_beat_o   = wr;
  assign rd_bus_o    = rd ? src_q : 2'd0;
  assign wr_bus_o    = wr ? dst_q : 2'd0;
  assign beat_half_o = (rd || wr) && half_q;
  assign byte_en_o   = (rd || wr) ? ((ew_q == EW_8) ? 2'b01 : 2'b11) : 2'b00;

  assert_full_rate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !two_cyc && !last) |=> wr_beat_o);
  assert_split_beat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && same) |-> !(rd_beat_o && wr_beat_o));
  assert_periph_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && periph) |=> !wr_beat_o);
  assert_half_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wide && !half_q) |=> half_q);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));
  assert_zero_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_count_i == '0) |=> (done_o && !rd_beat_o && !wr_beat_o));
  assert_busy_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> ($stable(src_q) && $stable(dst_q) && $stable(ew_q)));
endmodule

// File: rtl/dss_chan_map.sv
module dss_chan_map #(
  parameter int NUM_CHAN   = 12,
  parameter int NUM_PERIPH = 12,
  parameter int MAP_W      = 4,
  parameter int CH_W       = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  map_we_i,
  input  logic [CH_W-1:0]       map_chan_i,
  input  logic [MAP_W-1:0]      map_val_i,
  input  logic [NUM_PERIPH-1:0] periph_req_i,
  output logic [NUM_CHAN-1:0]   chan_req_o
);
  logic [MAP_W-1:0]      map_q [NUM_CHAN];
  logic [NUM_PERIPH-1:0] taken;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                map_q[c] <= MAP_W'(c);
      else if (map_we_i && map_chan_i == CH_W'(c)) map_q[c] <= map_val_i;
    end

    assert_unmapped_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(map_q[c]) >= NUM_PERIPH) |-> !chan_req_o[c]);
    assert_map_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (map_we_i && map_chan_i == CH_W'(c)) |=> (map_q[c] == $past(map_val_i)));
  end

  // lowest channel claims a shared peripheral
  always_comb begin
    taken      = '0;
    chan_req_o = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (int'(map_q[c]) < NUM_PERIPH) begin
        if (!taken[map_q[c]]) chan_req_o[c] = periph_req_i[map_q[c]];
        taken[map_q[c]] = 1'b1;
      end
    end
  end

  assert_single_owner_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(periph_req_i)) |-> $onehot0(chan_req_o));
endmodule

// File: rtl/dss_top.sv
module dss_top #(
  parameter int CNT_W      = 8,
  parameter int NUM_CHAN   = 12,
  parameter int NUM_PERIPH = 12,
  parameter int MAP_W      = 4,
  localparam int CH_W      = $clog2(NUM_CHAN)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [1:0]            req_src_i,
  input  logic [1:0]            req_dst_i,
  input  logic [1:0]            req_width_i,
  input  logic [CNT_W-1:0]      req_count_i,
  output logic                  ready_o,
  output logic                  rd_beat_o,
  output logic [1:0]            rd_bus_o,
  output logic                  wr_beat_o,
  output logic [1:0]            wr_bus_o,
  output logic                  beat_half_o,
  output logic [1:0]            byte_en_o,
  output logic                  done_o,
  input  logic                  map_we_i,
  input  logic [CH_W-1:0]       map_chan_i,
  input  logic [MAP_W-1:0]      map_val_i,
  input  logic [NUM_PERIPH-1:0] periph_req_i,
  output logic [NUM_CHAN-1:0]   chan_req_o
);
  dss_beat_ctl #(.CNT_W(CNT_W)) u_beat (
    .clk_i, .rst_ni, .req_valid_i, .req_src_i, .req_dst_i, .req_width_i, .req_count_i,
    .ready_o, .rd_beat_o, .rd_bus_o, .wr_beat_o, .wr_bus_o, .beat_half_o, .byte_en_o, .done_o
  );

  dss_chan_map #(.NUM_CHAN(NUM_CHAN), .NUM_PERIPH(NUM_PERIPH), .MAP_W(MAP_W), .CH_W(CH_W)) u_map (
    .clk_i, .rst_ni, .map_we_i, .map_chan_i, .map_val_i, .periph_req_i, .chan_req_o
  );

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!rd_beat_o && !wr_beat_o && !done_o));
endmodule

// File: tb/dss_top_test.sv
module dss_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_src = '0, req_dst = '0, req_width = '0;
  logic [3:0]  req_count = '0;
  logic        ready, rd_beat, wr_beat, beat_half, done;
  logic [1:0]  rd_bus, wr_bus, byte_en;
  logic        map_we = 1'b0;
  logic [3:0]  map_chan = '0, map_val = '0;
  logic [11:0] periph_req = '0;
  logic [11:0] chan_req;

  int    n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";
  logic [9:0] exp_q[$];

  always #2 clk = ~clk;

  dss_top #(.CNT_W(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_src_i(req_src),
    .req_dst_i(req_dst), .req_width_i(req_width), .req_count_i(req_count),
    .ready_o(ready), .rd_beat_o(rd_beat), .rd_bus_o(rd_bus), .wr_beat_o(wr_beat),
    .wr_bus_o(wr_bus), .beat_half_o(beat_half), .byte_en_o(byte_en), .done_o(done),
    .map_we_i(map_we), .map_chan_i(map_chan), .map_val_i(map_val),
    .periph_req_i(periph_req), .chan_req_o(chan_req)
  );

  function automatic logic [9:0] rec(bit rd, bit wr, logic [1:0] rb, logic [1:0] wb,
                                     bit h, logic [1:0] be, bit dn);
    return {rd, wr, rb, wb, h, be, dn};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      logic [9:0] e;
      e = exp_q.pop_front();
      chk(cur_tag, 32'({rd_beat, wr_beat, rd_bus, wr_bus, beat_half, byte_en, done}), 32'(e));
    end
  end

  task automatic run_xfer(string tag, logic [1:0] s, logic [1:0] d, logic [1:0] w, int n, bit hold);
    int bpe, total;
    bit same, per;
    logic [1:0] be;
    bpe   = (w == 2'd2) ? 2 : 1;
    total = n * bpe;
    same  = (s == d);
    per   = (s == 2'd1) || (d == 2'd1);
    be    = (w == 2'd0) ? 2'b01 : 2'b11;
    @(negedge clk);
    req_src = s; req_dst = d; req_width = w; req_count = 4'(n); req_valid = 1'b1;
    @(posedge clk);
    #1;
    cur_tag = tag;
    for (int b = 0; b < total; b++) begin
      bit h;
      h = (bpe == 2) ? bit'(b % 2) : 1'b0;
      if (same) begin
        exp_q.push_back(rec(1, 0, s, 2'd0, h, be, 0));
        exp_q.push_back(rec(0, 1, 2'd0, d, h, be, 0));
      end else begin
        exp_q.push_back(rec(1, 1, s, d, h, be, 0));
        if (per && b != total - 1) exp_q.push_back(rec(0, 0, 2'd0, 2'd0, 0, 2'b00, 0));
      end
    end
    exp_q.push_back(rec(0, 0, 2'd0, 2'd0, 0, 2'b00, 1));
    if (hold) begin
      req_src = 2'd2; req_dst = 2'd0; req_width = 2'd0; req_count = 4'd3;
      @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk({tag, " R2 ready after done"}, 32'(ready), 32'd1);
  endtask

  task automatic map_write(logic [3:0] c, logic [3:0] v);
    @(negedge clk);
    map_we = 1'b1; map_chan = c; map_val = v;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic map_probe(string tag, int p, logic [11:0] exp);
    @(negedge clk);
    periph_req = 12'(1) << p;
    #1;
    chk(tag, 32'(chan_req), 32'(exp));
    periph_req = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(ready), 32'd1);
    chk("R1 no beats", 32'({rd_beat, wr_beat, done}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(ready), 32'd1);
    map_probe("R1 identity map ch5", 5, 12'(1) << 5);
    map_probe("R1 identity map ch11", 11, 12'(1) << 11);

    run_xfer("R3 local->ext 16b", 2'd0, 2'd2, 2'd1, 5, 0);
    run_xfer("R7 ext->local 8b", 2'd2, 2'd0, 2'd0, 3, 0);
    run_xfer("R4 local->local", 2'd0, 2'd0, 2'd1, 3, 0);
    run_xfer("R4 ext->ext", 2'd2, 2'd2, 2'd1, 2, 0);
    run_xfer("R5 periph->local", 2'd1, 2'd0, 2'd1, 4, 0);
    run_xfer("R5 ext->periph 32b", 2'd2, 2'd1, 2'd2, 2, 0);
    run_xfer("R6 local->ext 32b", 2'd0, 2'd2, 2'd2, 3, 0);
    run_xfer("R8 count 15", 2'd0, 2'd2, 2'd1, 15, 0);
    run_xfer("R9 count zero", 2'd0, 2'd2, 2'd1, 0, 0);
    run_xfer("R13 busy request", 2'd0, 2'd2, 2'd1, 6, 1);

    map_write(4'd7, 4'd5);
    map_probe("R10 remap ch7 no effect on ch2", 2, 12'(1) << 2);
    map_probe("R12 ch5 wins over ch7", 5, 12'(1) << 5);
    map_write(4'd5, 4'd14);
    map_probe("R11 ch5 unconnected, ch7 takes p5", 5, 12'(1) << 7);
    map_write(4'd13, 4'd0);
    map_probe("R10 out-of-range channel ignored ch1", 1, 12'(1) << 1);
    map_probe("R10 out-of-range channel ignored ch0", 0, 12'(1) << 0);
    @(negedge clk);
    periph_req = 12'hFFF;
    #1;
    chk("R11 unconnected ch5 stays low", 32'(chan_req[5]), 32'd0);
    periph_req = '0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule